// File: doc/BRIEF.md
# Fast Ethernet Receive Stream Framer

This block sits after code-group alignment and descrambling in a 100 Mb/s twisted-pair receive path. It takes one aligned 5-bit code group per 25 MHz clock and turns the stream into the media-independent receive signals: carrier sense, data valid, receive error and a 4-bit data nibble. It finds where frames start and end from the delimiter pairs on the line. It decodes data code groups back to nibbles, and it reports damaged or cut-off frames to the MAC.

A frame starts on the start delimiter pair. That pair is handed to the MAC as two preamble nibbles, so data valid is already high for the first preamble nibble. A frame ends cleanly on the end delimiter pair. If the line falls back to IDLE with no end delimiter, carrier drops and the framer flags a one-clock receive error. To match each code group with the one that follows it, the framer holds one code group of lookahead. Every code group therefore shows at the outputs after a fixed latency of two clock edges.

Top module: `fe_rx_framer`

## Requirements
- R1: The start delimiter is the code group 11000 followed at once by 10001. It raises carrier and data valid, and it is output as two nibbles of 0x5 with no error. The outputs for the code group presented before rising edge n appear after rising edge n+1.
- R2: Inside a frame, a data code group is output as its nibble, with carrier and data valid high and error low. The code groups for 0x0 to 0xF are 11110, 01001, 10100, 10101, 01010, 01011, 01110, 01111, 10010, 10011, 10110, 10111, 11010, 11011, 11100 and 11101.
- R3: Inside a frame, the pair 01101 followed by 10000-free 00111 ends the frame. Carrier, data valid and error are all low for both code groups of the pair, and RXD is zero.
- R4: Inside a frame, the code group 11111 with no end pair before it drops carrier and data valid. Error is high for exactly that one clock, and the framer returns to idle.
- R5: Inside a frame, a code group that is neither data, nor the start of an end pair, nor 11111 (for example 11000, 10001, a lone 00111, or a reserved value) gives error high with carrier and data valid high and RXD zero. The frame continues.
- R6: A 11000 that is not followed by 10001 is a false carrier: carrier never rises and the framer stays idle.
- R7: With carrier inactive, data valid is low and RXD is zero. Error is low except for the pulse in R4.
- R8: While reset is asserted, all outputs are low.
- R9: A start pair that follows an end pair immediately is accepted as a new frame.
- R10: A 01101 that is not followed by 00111 is treated as an invalid code group per R5, and the frame continues.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 25 MHz receive clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cg_in | input | 5 | Aligned received code group, one per clock |
| crs | output | 1 | Carrier sense |
| rx_dv | output | 1 | Receive data valid |
| rx_er | output | 1 | Receive error |
| rxd | output | 4 | Received nibble |

## Verification
A framer stuck in the wrong state shows at the ports within two clock edges of the code group that exposes it. A missed end pair keeps carrier high through the trailing IDLE and turns it into a spurious error pulse. A spurious start leaves carrier high with no preamble. The sweep places every one of the 32 code-group values inside a frame and checks each output nibble against a model built from the requirements. This makes a wrong decode entry, a misplaced error, or a skipped delimiter state visible on a known cycle.

// File: rtl/fe_rx_pkg.sv
package fe_rx_pkg;
   localparam logic [4:0] CG_J    = 5'b11000;
   localparam logic [4:0] CG_K    = 5'b10001;
   localparam logic [4:0] CG_T    = 5'b01101;
   localparam logic [4:0] CG_R    = 5'b00111;
   localparam logic [4:0] CG_IDLE = 5'b11111;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_PRE2 = 2'd1,
      ST_DATA = 2'd2,
      ST_TAIL = 2'd3
   } frm_state_e;

   // code group carrying a given data nibble
   function automatic logic [4:0] nib_to_cg(input logic [3:0] n);
      logic [4:0] c;
      case (n)
         4'h0: c = 5'b11110;  4'h1: c = 5'b01001;
         4'h2: c = 5'b10100;  4'h3: c = 5'b10101;
         4'h4: c = 5'b01010;  4'h5: c = 5'b01011;
         4'h6: c = 5'b01110;  4'h7: c = 5'b01111;
         4'h8: c = 5'b10010;  4'h9: c = 5'b10011;
         4'hA: c = 5'b10110;  4'hB: c = 5'b10111;
         4'hC: c = 5'b11010;  4'hD: c = 5'b11011;
         4'hE: c = 5'b11100;  default: c = 5'b11101;
      endcase
      return c;
   endfunction
endpackage

// File: rtl/fe_rx_cg_decode.sv
module fe_rx_cg_decode
   import fe_rx_pkg::*;
#(
   parameter int CG_W       = 5,
   parameter int NIB_W      = 4,
   parameter bit USE_SEARCH = 1'b0
) (
   input  logic [CG_W-1:0]  cg,
   output logic [NIB_W-1:0] nib,
   output logic             is_data,
   output logic             is_j,
   output logic             is_t,
   output logic             is_idle
);
   localparam int N_SYM = 1 << NIB_W;

   assign is_j    = (cg == CG_J);
   assign is_t    = (cg == CG_T);
   assign is_idle = (cg == CG_IDLE);

   generate
      if (USE_SEARCH) begin : g_search
         always_comb begin
            nib     = '0;
            is_data = 1'b0;
            for (int i = 0; i < N_SYM; i++) begin
               if (cg == nib_to_cg(NIB_W'(i))) begin
                  nib     = NIB_W'(i);
                  is_data = 1'b1;
               end
            end
         end
      end else begin : g_case
         always_comb begin
            is_data = 1'b1;
            case (cg)
               5'b11110: nib = 4'h0;  5'b01001: nib = 4'h1;
               5'b10100: nib = 4'h2;  5'b10101: nib = 4'h3;
               5'b01010: nib = 4'h4;  5'b01011: nib = 4'h5;
               5'b01110: nib = 4'h6;  5'b01111: nib = 4'h7;
               5'b10010: nib = 4'h8;  5'b10011: nib = 4'h9;
               5'b10110: nib = 4'hA;  5'b10111: nib = 4'hB;
               5'b11010: nib = 4'hC;  5'b11011: nib = 4'hD;
               5'b11100: nib = 4'hE;  5'b11101: nib = 4'hF;
               default: begin nib = '0; is_data = 1'b0; end
            endcase
         end
      end
   endgenerate
endmodule

// File: rtl/fe_rx_fsm.sv
module fe_rx_fsm
   import fe_rx_pkg::*;
#(
   parameter int              CG_W    = 5,
   parameter int              NIB_W   = 4,
   parameter logic [NIB_W-1:0] PRE_NIB = 4'h5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NIB_W-1:0] cur_nib,
   input  logic             cur_data,
   input  logic             cur_j,
   input  logic             cur_t,
   input  logic             cur_idle,
   input  logic [CG_W-1:0]  la_cg,
   output logic             crs,
   output logic             rx_dv,
   output logic             rx_er,
   output logic [NIB_W-1:0] rxd
);
   frm_state_e st, nxt;
   logic             n_crs, n_dv, n_er;
   logic [NIB_W-1:0] n_nib;
   logic             la_k, la_r;

   assign la_k = (la_cg == CG_K);
   assign la_r = (la_cg == CG_R);

   always_comb begin
      nxt   = st;
      n_crs = 1'b0;
      n_dv  = 1'b0;
      n_er  = 1'b0;
      n_nib = '0;
      case (st)
         ST_IDLE: begin
            if (cur_j && la_k) begin
               nxt = ST_PRE2; n_crs = 1'b1; n_dv = 1'b1; n_nib = PRE_NIB;
            end
         end
         ST_PRE2: begin
            nxt = ST_DATA; n_crs = 1'b1; n_dv = 1'b1; n_nib = PRE_NIB;
         end
         ST_DATA: begin
            if (cur_t && la_r) begin
               nxt = ST_TAIL;
            end else if (cur_idle) begin
               nxt = ST_IDLE; n_er = 1'b1;
            end else begin
               n_crs = 1'b1; n_dv = 1'b1;
               if (cur_data) n_nib = cur_nib;
               else          n_er  = 1'b1;
            end
         end
         default: nxt = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st    <= ST_IDLE;
         crs   <= 1'b0;
         rx_dv <= 1'b0;
         rx_er <= 1'b0;
         rxd   <= '0;
      end else begin
         st    <= nxt;
         crs   <= n_crs;
         rx_dv <= n_dv;
         rx_er <= n_er;
         rxd   <= n_nib;
      end
   end

   // R3: after an end pair is taken, the next output is quiet
   a_r3_tail_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_TAIL) |=> (!crs && !rx_dv && !rx_er));
   // R1: preamble state always follows a start hit
   a_r1_pre_follows: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_PRE2) |-> (crs && rx_dv && rxd == PRE_NIB));
endmodule

// File: rtl/fe_rx_framer.sv
module fe_rx_framer
   import fe_rx_pkg::*;
#(
   parameter int               CG_W       = 5,
   parameter int               NIB_W      = 4,
   parameter logic [NIB_W-1:0] PRE_NIB    = 4'h5,
   parameter bit               USE_SEARCH = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CG_W-1:0]  cg_in,
   output logic             crs,
   output logic             rx_dv,
   output logic             rx_er,
   output logic [NIB_W-1:0] rxd
);
   generate
      if (CG_W != 5)  begin : g_bad_cg  $error("CG_W must be 5");  end
      if (NIB_W != 4) begin : g_bad_nib $error("NIB_W must be 4"); end
   endgenerate

   logic [CG_W-1:0]  cg_q;
   logic [NIB_W-1:0] d_nib;
   logic             d_data, d_j, d_t, d_idle;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cg_q <= CG_IDLE;
      else        cg_q <= cg_in;
   end

   fe_rx_cg_decode #(.CG_W(CG_W), .NIB_W(NIB_W), .USE_SEARCH(USE_SEARCH)) u_dec (
      .cg(cg_q), .nib(d_nib), .is_data(d_data), .is_j(d_j),
      .is_t(d_t), .is_idle(d_idle)
   );

   fe_rx_fsm #(.CG_W(CG_W), .NIB_W(NIB_W), .PRE_NIB(PRE_NIB)) u_fsm (
      .clk(clk), .rst_n(rst_n), .cur_nib(d_nib), .cur_data(d_data),
      .cur_j(d_j), .cur_t(d_t), .cur_idle(d_idle), .la_cg(cg_in),
      .crs(crs), .rx_dv(rx_dv), .rx_er(rx_er), .rxd(rxd)
   );

   // R1: carrier rises with two preamble nibbles
   a_r1_crs_rise: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(crs) |-> (rx_dv && !rx_er && rxd == PRE_NIB));
   a_r1_second_pre: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(crs) |=> (crs && rx_dv && rxd == PRE_NIB));
   // R4: abort error lasts one clock
   a_r4_er_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_er && !crs) |=> !rx_er);
   // R5: an in-frame error keeps data valid
   a_r5_er_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_er && crs) |-> (rx_dv && rxd == '0));
   // R7: no carrier, no data
   a_r7_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !crs |-> (!rx_dv && rxd == '0));
   a_r7_dv_needs_crs: assert property (@(posedge clk) disable iff (!rst_n)
      rx_dv |-> crs);
endmodule

// File: tb/fe_rx_framer_bench.sv
module fe_rx_framer_bench;
   localparam int CLK_PERIOD = 40;
   localparam int MAXN = 1024;

   logic       clk = 1'b0, rst_n = 1'b0;
   logic [4:0] cg_in = 5'b11111;
   logic       crs, rx_dv, rx_er;
   logic [3:0] rxd;

   int n_tests = 0, n_fail = 0, nseq = 0;
   logic [4:0] seq [MAXN];
   logic [6:0] expv [MAXN];
   string      tag [MAXN];

   always #(CLK_PERIOD/2) clk = ~clk;

   fe_rx_framer u_fe_rx_framer (.clk(clk), .rst_n(rst_n), .cg_in(cg_in),
      .crs(crs), .rx_dv(rx_dv), .rx_er(rx_er), .rxd(rxd));

   function automatic logic [4:0] enc(input int n);
      logic [4:0] t [16] = '{5'b11110, 5'b01001, 5'b10100, 5'b10101,
                             5'b01010, 5'b01011, 5'b01110, 5'b01111,
                             5'b10010, 5'b10011, 5'b10110, 5'b10111,
                             5'b11010, 5'b11011, 5'b11100, 5'b11101};
      return t[n];
   endfunction

   task automatic push(input logic [4:0] c);
      seq[nseq] = c; nseq++;
   endtask

   task automatic check(input logic [6:0] e, input string t);
      n_tests++;
      if ({crs, rx_dv, rx_er, rxd} !== e) begin
         n_fail++;
         $display("FAIL %s: got crs/dv/er/rxd=%b expected %b", t,
                  {crs, rx_dv, rx_er, rxd}, e);
      end
   endtask

   // requirement model: states 0 idle, 1 second preamble, 2 data, 3 end tail
   task automatic build_expect();
      int st = 0;
      for (int i = 0; i < nseq; i++) begin
         logic [4:0] c, n;
         int dn;
         c = seq[i];
         n = (i + 1 < nseq) ? seq[i+1] : 5'b11111;
         dn = -1;
         for (int k = 0; k < 16; k++) if (enc(k) == c) dn = k;
         expv[i] = 7'b0;
         case (st)
            0: begin
               tag[i] = (c == 5'b11000) ? "R6" : "R7";
               if (c == 5'b11000 && n == 5'b10001) begin
                  expv[i] = 7'b110_0101; tag[i] = "R1"; st = 1;
               end
            end
            1: begin expv[i] = 7'b110_0101; tag[i] = "R1"; st = 2; end
            2: begin
               if (c == 5'b01101 && n == 5'b00111) begin
                  tag[i] = "R3"; st = 3;
               end else if (c == 5'b11111) begin
                  expv[i] = 7'b001_0000; tag[i] = "R4"; st = 0;
               end else if (dn >= 0) begin
                  expv[i] = {3'b110, 4'(dn)}; tag[i] = "R2";
               end else begin
                  expv[i] = 7'b111_0000;
                  tag[i] = (c == 5'b01101) ? "R10" : "R5";
               end
            end
            default: begin tag[i] = "R3"; st = 0; end
         endcase
      end
   endtask

   initial begin
      fork
         begin
            // R8: outputs stay low through reset even with a start pair
            @(negedge clk); cg_in = 5'b11000;
            @(negedge clk); cg_in = 5'b10001; check(7'b0, "R8");
            @(negedge clk); cg_in = 5'b11111; check(7'b0, "R8");
            rst_n = 1'b1;
            for (int i = 0; i < 4; i++) push(5'b11111);
            // sweep all 32 code groups inside a frame (R2 R4 R5 R10)
            for (int x = 0; x < 32; x++) begin
               push(5'b11000); push(5'b10001); push(5'(x));
               push(enc(10)); push(5'b01101); push(5'b00111);
               push(5'b11111); push(5'b11111);
            end
            // R6: false carrier
            push(5'b11000); push(5'b11111); push(5'b11000); push(enc(3));
            push(5'b11000); push(5'b11000); push(5'b11111);
            // R9: back-to-back frames
            push(5'b11000); push(5'b10001); push(enc(1)); push(enc(2));
            push(5'b01101); push(5'b00111); push(5'b11000); push(5'b10001);
            push(enc(3)); push(5'b01101); push(5'b00111); push(5'b11111);
            // R2: every nibble in one frame
            push(5'b11000); push(5'b10001);
            for (int k = 0; k < 16; k++) push(enc(k));
            push(5'b01101); push(5'b00111); push(5'b11111); push(5'b11111);
            build_expect();
            for (int j = 0; j < nseq + 2; j++) begin
               @(negedge clk);
               if (j >= 2) check(expv[j-2], tag[j-2]);
               cg_in = (j < nseq) ? seq[j] : 5'b11111;
            end
         end
         begin
            repeat (100000) @(posedge clk);
            n_tests++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
         end
      join_any
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule